// File: doc/BRIEF.md
# Power-Fail Chip-Enable Write Protector

This block sits between a host and an SRAM. It gates the memory's active-low chip enable while the supply is failing and while it recovers. The host's active-low enable and a digital power-good flag from an external supply comparator come in. The active-low enable for the memory goes out.

While the supply is healthy and settled, the host enable reaches the memory unchanged through a combinational path. When power-good drops, an access that is already in progress may complete, but only for a bounded grace period counted in clock cycles. After that the memory enable is held inactive. It stays inactive until power-good has been back for a recovery interval. Both intervals are parameters, so a system can set them from its clock rate and a simulation can keep them short.

The power-good flag is asynchronous to the clock, so it passes through a flip-flop synchronizer before any decision uses it. Out of reset the block treats the memory as unprotected-unsafe: it starts in recovery with the output inactive.

Top module: `ce_guard`

## Requirements
- R1: During reset and after it, `memCeN` is 1 (inactive). It stays 1 until the synchronised power-good has been seen high on REC_CYCLES+1 consecutive rising edges.
- R2: Once settled (no failure pending and recovery complete), `memCeN` equals `hostCeN` in the same cycle, with no register between them.
- R3: `powerGood` passes through a SYNC_STAGES flip-flop synchronizer (default 2). A drop therefore acts on the rising edge SYNC_STAGES+1 edges after the cycle in which it is applied. Until then, pass-through continues.
- R4: If `hostCeN` is 1 on the edge where the synchronised failure is acted on, `memCeN` is 1 from that edge onward.
- R5: If `hostCeN` is 0 on that edge, a grace period starts and `memCeN` follows `hostCeN`. The first edge during grace that samples `hostCeN` = 1 ends the grace period. From then on `memCeN` is 1, even if `hostCeN` returns to 0.
- R6: If `hostCeN` is still 0 after GRACE_CYCLES edges of grace, `memCeN` is forced to 1 from that edge onward.
- R7: Once protection has latched, `memCeN` stays 1 for as long as power is bad. A return of power-good during the grace period neither extends nor cancels grace: the latch still follows and a full recovery is needed.
- R8: After the synchronised power-good returns, `memCeN` stays 1 until REC_CYCLES+1 consecutive edges have seen it high. Pass-through then resumes.
- R9: A drop of power-good during recovery latches protection again and restarts the recovery count from zero.
- R10: `memCeN` is never 0 while `hostCeN` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all timing counted in its cycles |
| rstN | input | 1 | Synchronous active-low reset |
| hostCeN | input | 1 | Active-low chip enable from the host |
| powerGood | input | 1 | Asynchronous power-good flag from the supply comparator, 1 = in tolerance |
| memCeN | output | 1 | Active-low chip enable to the SRAM |

## Verification
The bench targets these corner cases:

- **Power-good drop while the host enable is active.** A design that protects at once would cut the access short. A design without a bound would let a stuck host keep the memory enabled through the whole failure.
- **Host enable released and then reasserted within grace.** A leaky latch would re-enable the memory.
- **Power-good returning before grace ends, and a glitch mid-recovery.** A design that shortens grace or fails to restart its recovery count would open the memory early.
- **Synchronizer latency and long randomised traffic.** These are compared edge for edge against a behavioural model. An off-by-one in the grace or recovery count shows up as a single mismatched cycle.

// File: rtl/ce_guard_pkg.sv
package ce_guard_pkg;

  typedef enum logic [1:0] {
    ST_RECOVER = 2'd0,
    ST_PASS    = 2'd1,
    ST_GRACE   = 2'd2,
    ST_LOCKED  = 2'd3
  } guard_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic passEn;
  } guard_strobe_t;

endpackage

// File: rtl/ce_guard_sync.sv
module ce_guard_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic dIn,
  output logic dOut
);
  logic [STAGES-1:0] stage;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) stage[0] <= 1'b0;
          else       stage[0] <= dIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) stage[i] <= 1'b0;
          else       stage[i] <= stage[i-1];
        end
      end
    end
  endgenerate

  assign dOut = stage[STAGES-1];
endmodule

// File: rtl/ce_guard_ctrl.sv
module ce_guard_ctrl
  import ce_guard_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          pgOk,
  input  logic          hostCeN,
  input  logic          graceDone,
  input  logic          recDone,
  output guard_strobe_t strobe
);
  guard_state_e state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_RECOVER;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_RECOVER: begin
        if (!pgOk) begin
          stateNext     = ST_LOCKED;
          strobe.cntClr = 1'b1;
        end else if (recDone) begin
          stateNext     = ST_PASS;
          strobe.cntClr = 1'b1;
        end else begin
          strobe.cntInc = 1'b1;
        end
      end
      ST_PASS: begin
        strobe.passEn = 1'b1;
        strobe.cntClr = 1'b1;
        if (!pgOk) stateNext = hostCeN ? ST_LOCKED : ST_GRACE;
      end
      ST_GRACE: begin
        // grace ignores power-good; only the host or the timer ends it
        strobe.passEn = 1'b1;
        if (hostCeN || graceDone) begin
          stateNext     = ST_LOCKED;
          strobe.cntClr = 1'b1;
        end else begin
          strobe.cntInc = 1'b1;
        end
      end
      ST_LOCKED: begin
        strobe.cntClr = 1'b1;
        if (pgOk) stateNext = ST_RECOVER;
      end
      default: begin
        stateNext     = ST_LOCKED;
        strobe.cntClr = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/ce_guard_dp.sv
module ce_guard_dp
  import ce_guard_pkg::*;
#(
  parameter int GRACE_CYCLES = 8,
  parameter int REC_CYCLES   = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          hostCeN,
  input  guard_strobe_t strobe,
  output logic          graceDone,
  output logic          recDone,
  output logic          memCeN
);
  localparam int MAX_CNT = (GRACE_CYCLES > REC_CYCLES) ? GRACE_CYCLES : REC_CYCLES;
  localparam int CW      = $clog2(MAX_CNT + 1);
  localparam logic [CW-1:0] GRACE_LAST = CW'(GRACE_CYCLES - 1);
  localparam logic [CW-1:0] REC_LAST   = CW'(REC_CYCLES - 1);

  logic [CW-1:0] cycleCnt;

  always_ff @(posedge clk) begin
    if (!rstN)              cycleCnt <= '0;
    else if (strobe.cntClr) cycleCnt <= '0;
    else if (strobe.cntInc) cycleCnt <= cycleCnt + 1'b1;
  end

  assign graceDone = (cycleCnt == GRACE_LAST);
  assign recDone   = (cycleCnt == REC_LAST);

  // combinational pass-through; forced high when not enabled
  assign memCeN = hostCeN | ~strobe.passEn;
endmodule

// File: rtl/ce_guard.sv
module ce_guard
  import ce_guard_pkg::*;
#(
  parameter int GRACE_CYCLES = 8,
  parameter int REC_CYCLES   = 16,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic hostCeN,
  input  logic powerGood,
  output logic memCeN
);
  logic          pgOk;
  logic          graceDone;
  logic          recDone;
  guard_strobe_t strobe;

  ce_guard_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .dIn  (powerGood),
    .dOut (pgOk)
  );

  ce_guard_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .pgOk      (pgOk),
    .hostCeN   (hostCeN),
    .graceDone (graceDone),
    .recDone   (recDone),
    .strobe    (strobe)
  );

  ce_guard_dp #(
    .GRACE_CYCLES (GRACE_CYCLES),
    .REC_CYCLES   (REC_CYCLES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .hostCeN   (hostCeN),
    .strobe    (strobe),
    .graceDone (graceDone),
    .recDone   (recDone),
    .memCeN    (memCeN)
  );
endmodule

// File: rtl/ce_guard_chk.sv
module ce_guard_chk #(
  parameter int GRACE_CYCLES = 8,
  parameter int REC_CYCLES   = 16,
  parameter int SYNC_STAGES  = 2
) (
  input logic clk,
  input logic rstN,
  input logic hostCeN,
  input logic powerGood,
  input logic memCeN
);
  localparam int LIM = ((GRACE_CYCLES > REC_CYCLES) ? GRACE_CYCLES : REC_CYCLES) + 2;
  localparam int CW  = $clog2(LIM + 1);
  localparam logic [CW-1:0] LIM_V   = CW'(LIM);
  localparam logic [CW-1:0] GRACE_V = CW'(GRACE_CYCLES);
  localparam logic [CW-1:0] REC_V   = CW'(REC_CYCLES);

  // independent observation of the synchronised power flag
  logic [SYNC_STAGES-1:0] pgPipe;
  logic                   pgSeen;
  always_ff @(posedge clk) begin
    if (!rstN) pgPipe <= '0;
    else       pgPipe <= {pgPipe, powerGood};
  end
  assign pgSeen = pgPipe[SYNC_STAGES-1];

  logic [CW-1:0] badRun;
  logic [CW-1:0] goodRun;

  always_ff @(posedge clk) begin
    if (!rstN)             badRun <= '0;
    else if (pgSeen)       badRun <= '0;
    else if (badRun < LIM_V) badRun <= badRun + 1'b1;
  end

  // counts good edges seen while the output was blocked; saturates once settled
  always_ff @(posedge clk) begin
    if (!rstN)                         goodRun <= '0;
    else if (!pgSeen)                  goodRun <= '0;
    else if (goodRun <= REC_V && !memCeN) goodRun <= '0;
    else if (goodRun <= REC_V)         goodRun <= goodRun + 1'b1;
  end

  p_reset_block_r1: assert property (@(posedge clk) !rstN |=> memCeN);

  p_pass_follow_r2: assert property (@(posedge clk) disable iff (!rstN)
    (goodRun > REC_V && $past(goodRun > REC_V)) |-> (memCeN == hostCeN));

  p_grace_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    (badRun > GRACE_V) |-> memCeN);

  p_latch_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!pgSeen) && $past(memCeN) && !pgSeen) |-> memCeN);

  p_recovery_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (goodRun != '0 && goodRun <= REC_V) |-> memCeN);

  p_no_spurious_r10: assert property (@(posedge clk) disable iff (!rstN)
    hostCeN |-> memCeN);
endmodule

bind ce_guard ce_guard_chk #(
  .GRACE_CYCLES (GRACE_CYCLES),
  .REC_CYCLES   (REC_CYCLES),
  .SYNC_STAGES  (SYNC_STAGES)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .hostCeN   (hostCeN),
  .powerGood (powerGood),
  .memCeN    (memCeN)
);

// File: tb/ce_guard_test.sv
module ce_guard_test;
  localparam int CLK_PERIOD = 10;
  localparam int G = 4;
  localparam int R = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostCeN = 1'b1;
  logic powerGood = 1'b0;
  logic memCeN;

  always #(CLK_PERIOD/2) clk = ~clk;

  ce_guard #(.GRACE_CYCLES(G), .REC_CYCLES(R), .SYNC_STAGES(2)) uut (
    .clk       (clk),
    .rstN      (rstN),
    .hostCeN   (hostCeN),
    .powerGood (powerGood),
    .memCeN    (memCeN)
  );

  int errors = 0;
  int checks = 0;

  // behavioural reference: synchronizer as a two-entry history,
  // settledness as a run of good edges, grace as a remaining budget
  logic pgHist[$];
  int   goodEdges = 0;
  bit   graceOn = 1'b0;
  int   graceLeft = 0;

  task automatic cyc(input logic h, input logic pg, input string tag);
    logic expOut;
    logic pgUsed;
    hostCeN   = h;
    powerGood = pg;
    @(negedge clk);
    expOut = (graceOn || goodEdges > R) ? h : 1'b1;
    checks++;
    if (memCeN !== expOut) begin
      errors++;
      $display("FAIL %s: memCeN=%b expected %b at %0t", tag, memCeN, expOut, $time);
    end
    @(posedge clk);
    pgUsed = pgHist[0];
    if (graceOn) begin
      graceLeft--;
      if (h || graceLeft == 0) graceOn = 1'b0;
      goodEdges = 0;
    end else if (pgUsed) begin
      if (goodEdges <= R) goodEdges++;
    end else begin
      if (goodEdges > R && !h) begin
        graceOn   = 1'b1;
        graceLeft = G;
      end
      goodEdges = 0;
    end
    void'(pgHist.pop_front());
    pgHist.push_back(pg);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: run did not end, actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    logic        pgRand;
    pgHist = '{1'b0, 1'b0};
    repeat (3) @(posedge clk);
    #1;
    // R1: reset holds the output inactive
    checks++;
    if (memCeN !== 1'b1) begin
      errors++;
      $display("FAIL R1: memCeN=%b expected 1 right after reset", memCeN);
    end
    rstN = 1'b1;

    // R1: initial recovery with host asking for the memory
    repeat (R + 3) cyc(1'b0, 1'b1, "R1");
    // R2: pass-through
    for (int i = 0; i < 8; i++) cyc(logic'(i[0] ^ i[2]), 1'b1, "R2");

    // R3: drop with host active - two more cycles of pass-through
    cyc(1'b0, 1'b0, "R3");
    cyc(1'b0, 1'b0, "R3");
    // R5: grace, then host releases, then re-asserts
    cyc(1'b0, 1'b0, "R5");
    cyc(1'b0, 1'b0, "R5");
    cyc(1'b1, 1'b0, "R5");
    repeat (5) cyc(1'b0, 1'b0, "R5");
    // R8: recovery
    repeat (R + 4) cyc(1'b0, 1'b1, "R8");
    for (int i = 0; i < 4; i++) cyc(logic'(i[0]), 1'b1, "R2");

    // R4: drop with host idle, then host tries to access
    repeat (4) cyc(1'b1, 1'b0, "R4");
    repeat (3) cyc(1'b0, 1'b0, "R4");
    repeat (R + 4) cyc(1'b0, 1'b1, "R8");

    // R6: host holds enable through the whole grace budget
    repeat (G + 6) cyc(1'b0, 1'b0, "R6");
    // R7: locked while power stays bad
    for (int i = 0; i < 6; i++) cyc(logic'(i[0]), 1'b0, "R7");
    repeat (R + 4) cyc(1'b0, 1'b1, "R8");

    // R7: power returns during grace
    repeat (3) cyc(1'b0, 1'b0, "R7");
    repeat (G + R + 6) cyc(1'b0, 1'b1, "R7");

    // R9: glitch in the middle of recovery
    repeat (4) cyc(1'b0, 1'b0, "R9");
    repeat (4) cyc(1'b0, 1'b1, "R9");
    cyc(1'b0, 1'b0, "R9");
    repeat (R + 6) cyc(1'b0, 1'b1, "R9");

    // R10: long pseudo-random traffic
    lfsr   = 16'hACE1;
    pgRand = 1'b1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[7:0] < 8'd10) pgRand = ~pgRand;
      cyc(lfsr[0] & lfsr[5], pgRand, "R10");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule